// File: doc/BRIEF.md
# Framed Serial Command Word Loader

This block takes 16-bit command words from a three-wire serial link: an active-low frame input, a serial clock and a data line. While the frame is low, the block shifts in one bit on each falling serial-clock edge. When a word is complete, it moves that word into the system clock domain. Each word is then presented to the register file as a single-cycle write strobe, together with a stable data bus.

The serial clock may run all the time, or it may rest high or low between transfers. A frame can carry any number of whole words back to back. If the frame rises in the middle of a word, the partial word is dropped.

The two leading bits of each word select its destination. A word that begins with two zeros is loaded into a local control register. Any other prefix is passed on with the prefix shown on a separate output, so that downstream logic can pick the target register.

Top module: `serial_cmd_loader`

## Requirements
- R1: After the synchronous reset, `wr_stb` and `ctl_stb` are 0, and `wr_data`, `wr_tag` and `ctl_reg` are all zero.
- R2: A word is 16 bits long and arrives most significant bit first. Bit values are sampled on falling edges of `ser_clk`.
- R3: Serial clock edges that occur while `frame_n` is high change nothing: no strobe appears, and the next framed word is received intact.
- R4: While `frame_n` stays low, every further group of 16 falling edges forms a new word. Each of these words is delivered in order.
- R5: If `frame_n` rises before the 16th bit of a word, that partial word is discarded. The next frame then starts again from bit 15.
- R6: Words are received correctly whether `ser_clk` rests high or rests low between frames.
- R7: Each completed word produces exactly one `wr_stb` pulse of one `clk` cycle. `wr_data` holds the whole word and stays unchanged until the next pulse.
- R8: `wr_tag` equals bits 15:14 of the delivered word for all four prefix values.
- R9: A word with bits 15:14 equal to 00 raises `ctl_stb` together with `wr_stb` and loads `ctl_reg` with the word. A word with any other prefix leaves `ctl_reg` unchanged and does not raise `ctl_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (also clears the serial-side state) |
| frame_n | input | 1 | Active-low frame / enable |
| ser_clk | input | 1 | Serial clock; data is sampled on its falling edge |
| ser_din | input | 1 | Serial data, MSB first |
| wr_stb | output | 1 | One-cycle pulse for each received word |
| wr_data | output | 16 | Last received word |
| wr_tag | output | 2 | Destination prefix (bits 15:14 of `wr_data`) |
| ctl_stb | output | 1 | Pulse when the control register is loaded |
| ctl_reg | output | 16 | Control register contents |

## Verification
The main function is tested in three ways:
- A sweep of every prefix against data patterns of all zeros, all ones, alternating bits and mixed bits. Only a correct shift order and the correct bit count reproduce every one of these words exactly.
- A single frame carrying a walking-one train of 16 words. This separates correct word-boundary counting from off-by-one slips that a single-word frame cannot reveal.
- Truncated frames and clock bursts with the frame held high. These show whether the bit counter really restarts and whether stray edges are ignored.

Alternating the resting level of the serial clock between frames separates true falling-edge capture from capture that depends on the clock's level.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned TAG_W  = 2;
  localparam int unsigned SYNC_N = 2;
endpackage

// File: rtl/scl_shift.sv
module scl_shift #(
  parameter int unsigned W = scl_pkg::WORD_W
) (
  input  logic         rst,
  input  logic         frame_n,
  input  logic         ser_clk,
  input  logic         ser_din,
  output logic [W-1:0] word_o,
  output logic         tog_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          clr;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sreg;

  assign clr = rst | frame_n;

  // bit counter and shifter; held clear while the frame is idle
  always_ff @(negedge ser_clk or posedge clr) begin
    if (clr) begin
      cnt  <= '0;
      sreg <= '0;
    end else begin
      sreg <= {sreg[W-2:0], ser_din};
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // completed-word holding register and handoff toggle
  always_ff @(negedge ser_clk or posedge rst) begin
    if (rst) begin
      word_o <= '0;
      tog_o  <= 1'b0;
    end else if (!frame_n && cnt == LAST) begin
      word_o <= {sreg[W-2:0], ser_din};
      tog_o  <= ~tog_o;
    end
  end
endmodule

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned W      = scl_pkg::WORD_W,
  parameter int unsigned STAGES = scl_pkg::SYNC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tog_i,
  input  logic [W-1:0] word_i,
  output logic         pulse_o,
  output logic [W-1:0] word_o
);
  logic [STAGES:0] chain;

  assign chain[0] = tog_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i+1] <= 1'b0;
      else     chain[i+1] <= chain[i];
    end
  end

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      pulse_o <= 1'b0;
      word_o  <= '0;
    end else begin
      seen    <= chain[STAGES];
      pulse_o <= chain[STAGES] ^ seen;
      if (chain[STAGES] ^ seen) word_o <= word_i;
    end
  end
endmodule

// File: rtl/scl_route.sv
module scl_route #(
  parameter int unsigned W  = scl_pkg::WORD_W,
  parameter int unsigned TW = scl_pkg::TAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_i,
  input  logic [W-1:0]  word_i,
  output logic          wr_stb,
  output logic [W-1:0]  wr_data,
  output logic [TW-1:0] wr_tag,
  output logic          ctl_stb,
  output logic [W-1:0]  ctl_reg
);
  logic [TW-1:0] pfx;
  assign pfx = word_i[W-1 -: TW];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      wr_data <= '0;
      wr_tag  <= '0;
      ctl_stb <= 1'b0;
      ctl_reg <= '0;
    end else begin
      wr_stb  <= stb_i;
      ctl_stb <= stb_i && (pfx == '0);
      if (stb_i) begin
        wr_data <= word_i;
        wr_tag  <= pfx;
        if (pfx == '0) ctl_reg <= word_i;
      end
    end
  end
endmodule

// File: rtl/serial_cmd_loader.sv
module serial_cmd_loader #(
  parameter int unsigned W      = scl_pkg::WORD_W,
  parameter int unsigned TW     = scl_pkg::TAG_W,
  parameter int unsigned STAGES = scl_pkg::SYNC_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_n,
  input  logic          ser_clk,
  input  logic          ser_din,
  output logic          wr_stb,
  output logic [W-1:0]  wr_data,
  output logic [TW-1:0] wr_tag,
  output logic          ctl_stb,
  output logic [W-1:0]  ctl_reg
);
  logic [W-1:0] s_word, c_word;
  logic         s_tog, c_pulse;

  scl_shift #(.W(W)) shift_i (
    .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .word_o(s_word), .tog_o(s_tog)
  );

  scl_sync #(.W(W), .STAGES(STAGES)) sync_i (
    .clk(clk), .rst(rst), .tog_i(s_tog), .word_i(s_word),
    .pulse_o(c_pulse), .word_o(c_word)
  );

  scl_route #(.W(W), .TW(TW)) route_i (
    .clk(clk), .rst(rst), .stb_i(c_pulse), .word_i(c_word),
    .wr_stb(wr_stb), .wr_data(wr_data), .wr_tag(wr_tag),
    .ctl_stb(ctl_stb), .ctl_reg(ctl_reg)
  );
endmodule

// File: rtl/serial_cmd_loader_chk.sv
module serial_cmd_loader_chk #(
  parameter int unsigned W  = scl_pkg::WORD_W,
  parameter int unsigned TW = scl_pkg::TAG_W
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_stb,
  input logic [W-1:0]  wr_data,
  input logic [TW-1:0] wr_tag,
  input logic          ctl_stb,
  input logic [W-1:0]  ctl_reg
);
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R7
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |-> $stable(wr_data)); // R7
  AST_CTL_NEEDS_ZERO_PFX: assert property (@(posedge clk) disable iff (rst)
    ctl_stb |-> (wr_stb && wr_tag == '0)); // R9
  AST_CTL_LOADED: assert property (@(posedge clk) disable iff (rst)
    ctl_stb |-> ctl_reg == wr_data); // R9
  AST_CTL_HELD: assert property (@(posedge clk) disable iff (rst)
    !ctl_stb |-> $stable(ctl_reg)); // R9
  AST_PFX_SKIPS_CTL: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_tag != '0) |-> !ctl_stb); // R9
endmodule

bind serial_cmd_loader serial_cmd_loader_chk #(.W(W), .TW(TW)) chk_i (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
  .wr_tag(wr_tag), .ctl_stb(ctl_stb), .ctl_reg(ctl_reg)
);

// File: tb/serial_cmd_loader_tb_top.sv
module serial_cmd_loader_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic frame_n = 1'b1, ser_clk = 1'b1, ser_din = 1'b0;
  logic        wr_stb, ctl_stb;
  logic [15:0] wr_data, ctl_reg;
  logic [1:0]  wr_tag;

  int n_chk = 0, n_bad = 0;
  logic [15:0] fw [0:31];
  logic [15:0] exp_w [0:31];
  int exp_n = 0, got_n = 0;
  logic [15:0] exp_ctl = 16'h0;

  always #2 clk = ~clk;

  serial_cmd_loader dut_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .wr_stb(wr_stb), .wr_data(wr_data), .wr_tag(wr_tag),
    .ctl_stb(ctl_stb), .ctl_reg(ctl_reg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every strobe is compared with the next expected word
  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      if (got_n >= exp_n) begin
        chk(1'b0, "R3/R5 extra word", {16'h0, wr_data}, 32'h0);
      end else begin
        chk(wr_data == exp_w[got_n], "R2/R4 word value", {16'h0, wr_data}, {16'h0, exp_w[got_n]});
        chk(wr_tag == exp_w[got_n][15:14], "R8 tag", {30'h0, wr_tag}, {30'h0, exp_w[got_n][15:14]});
        if (exp_w[got_n][15:14] == 2'b00) exp_ctl = exp_w[got_n];
        chk(ctl_stb == (exp_w[got_n][15:14] == 2'b00), "R9 ctl strobe", {31'h0, ctl_stb},
            {31'h0, (exp_w[got_n][15:14] == 2'b00)});
        chk(ctl_reg == exp_ctl, "R9 ctl value", {16'h0, ctl_reg}, {16'h0, exp_ctl});
      end
      got_n++;
    end
  end

  // R7: a strobe never lasts two cycles
  logic prev_stb = 1'b0;
  always @(negedge clk) begin
    if (!rst && prev_stb && wr_stb) chk(1'b0, "R7 strobe width", 32'd2, 32'd1);
    prev_stb = wr_stb;
  end

  task automatic clock_bit(input logic d, input bit idle_hi);
    if (idle_hi) begin
      ser_din = d; #20 ser_clk = 1'b0; #20 ser_clk = 1'b1;
    end else begin
      ser_clk = 1'b1; ser_din = d; #20 ser_clk = 1'b0; #20;
    end
  endtask

  task automatic run_frame(input int n, input int bits_last, input bit idle_hi, input string req);
    int full;
    full = (bits_last == 16) ? n : n - 1;
    for (int k = 0; k < full; k++) exp_w[k] = fw[k];
    exp_n = full; got_n = 0;
    ser_clk = idle_hi; #30 frame_n = 1'b0; #30;
    for (int k = 0; k < n; k++) begin
      int nb;
      nb = (k == n - 1) ? bits_last : 16;
      for (int b = 15; b > 15 - nb; b--) clock_bit(fw[k][b], idle_hi);
    end
    #30 frame_n = 1'b1; #30;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(got_n == exp_n, req, got_n, exp_n);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_stb && !ctl_stb && wr_data == 0 && wr_tag == 0 && ctl_reg == 0, "R1 reset state",
        {wr_stb, ctl_stb, wr_tag, 12'h0, wr_data}, 32'h0);

    // R2 R6 R8 R9: every prefix against several data patterns, both idle levels
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 6; d++) begin
        logic [13:0] body;
        case (d)
          0: body = 14'h0000;
          1: body = 14'h3FFF;
          2: body = 14'h2AAA;
          3: body = 14'h1555;
          4: body = 14'(16'h0123 * (p + 3));
          default: body = 14'(16'h3C5A ^ (p * 16'h0111));
        endcase
        fw[0] = {p[1:0], body};
        run_frame(1, 16, d[0], "R2/R6 single word count");
      end
    end

    // R4: walking-one train of 16 words in one frame
    for (int k = 0; k < 16; k++) fw[k] = 16'h1 << k;
    run_frame(16, 16, 1'b0, "R4 stream count");

    // R4 R9: mixed prefixes streamed, control register must keep last 00 word
    fw[0] = 16'h0ABC; fw[1] = 16'h4321; fw[2] = 16'h8765; fw[3] = 16'hC0DE; fw[4] = 16'h1234; fw[5] = 16'hFFFF;
    run_frame(6, 16, 1'b1, "R4 mixed stream count");
    chk(ctl_reg == 16'h1234, "R9 ctl kept after nonzero prefix", {16'h0, ctl_reg}, 32'h1234);

    // R5: truncated word then a full word
    fw[0] = 16'hFFFF;
    run_frame(1, 7, 1'b0, "R5 partial discarded");
    fw[0] = 16'h0F0F;
    run_frame(1, 16, 1'b0, "R5 restart after partial");
    fw[0] = 16'h4000; fw[1] = 16'h3FFF;
    run_frame(2, 15, 1'b1, "R5 partial second word");

    // R3: clock bursts with frame high, then a clean word
    exp_n = 0; got_n = 0;
    for (int k = 0; k < 23; k++) begin
      ser_din = k[0]; #20 ser_clk = 1'b0; #20 ser_clk = 1'b1;
    end
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(got_n == 0, "R3 no word while frame high", got_n, 0);
    chk(ctl_reg == 16'h0F0F, "R3 ctl untouched", {16'h0, ctl_reg}, 32'h0F0F);
    fw[0] = 16'h2DB6;
    run_frame(1, 16, 1'b1, "R3 word after idle edges");
    chk(wr_data == 16'h2DB6, "R7 data held", {16'h0, wr_data}, 32'h2DB6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule